// File: doc/BRIEF.md
# Mode-Dependent Windowed Watchdog Controller

This block is the watchdog of a system supervisor. It measures the time between writes of the watchdog control word. Each write is a trigger, and each write also carries a new period code and a new mode-control bit. The watchdog behaviour is picked from three inputs: a disable pin, the current system operating mode and the stored mode-control bit. There are three behaviours. In window mode, a trigger that comes too early and a missing trigger both cause a system reset. In timeout mode, a lapse first raises a cyclic interrupt, and it forces a reset only when that interrupt is still pending. In off mode the timer is held.

The timer advances on a prescaled tick. By default one tick is one millisecond. Changing the disable pin or the mode-control bit while the system is active forces a reset at once.

The outputs are a one-cycle system-reset request, a one-cycle strobe that sets the cyclic interrupt, and the active watchdog mode. Reset pulse shaping and the register bus are handled outside this block.

Top module: `wdog_supervisor`

## Requirements
- R1: While `rst` is high, and on the cycle after it, `rst_req_o` and `ci_set_o` are 0 and `wd_mode_o` is 2'b00. The period code is set to 3'b100 and the mode-control bit to 0.
- R2: The watchdog mode is window (`wd_mode_o` = 2'b01) when `wd_dis_i` is 0, `sys_mode_i` is Normal (3'd0) and the mode-control bit is 0.
- R3: The watchdog mode is timeout (2'b10) when `wd_dis_i` is 0 and either the system is Normal with the mode-control bit at 1, or the system is Standby (3'd1) with the bit at 0.
- R4: The watchdog mode is off (2'b00) when `wd_dis_i` is 1, or the system is Sleep (3'd2), Off (3'd3) or Overtemp (3'd4), or the system is Standby with the bit at 1 and `irq_any_i` low. In Standby with the bit at 1, a high `irq_any_i` selects timeout instead.
- R5: In window mode, a trigger arriving while the elapsed tick count is below half the period requests a reset. A trigger at or after half the period restarts the count without a reset.
- R6: In window mode, a reset is requested when the count reaches the full period. A trigger in the same tick as that overflow counts as the overflow.
- R7: In timeout mode, a trigger restarts the count at any time. On overflow, `ci_set_o` pulses if `ci_pend_i` is 0, and `rst_req_o` pulses if `ci_pend_i` is 1.
- R8: Period codes 3'b000 through 3'b111 select 8, 16, 32, 64, 128, 256, 1024 and 4096 ms, multiplied by `TICKS_PER_MS`. The count advances only on `tick_i`. Every watchdog-caused reset restores code 3'b100, even when the write that caused the reset carried another code.
- R9: A change of `wd_dis_i` while the system is Normal or Standby requests a reset. A change in any other system mode does not.
- R10: A write that changes the mode-control bit while the system is Normal requests a reset.
- R11: In Standby with `irq_any_i` high, a write that would change the mode-control bit leaves the bit unchanged.
- R12: The outputs are registered, so they appear one cycle after the deciding edge. When a reset is requested, `ci_set_o` stays 0 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Prescaled timebase strobe, one per tick |
| trig_i | input | 1 | Write strobe of the watchdog control word (trigger) |
| trig_code_i | input | 3 | Period code carried by the write |
| trig_mc_i | input | 1 | Mode-control bit carried by the write |
| wd_dis_i | input | 1 | Watchdog disable pin |
| sys_mode_i | input | 3 | System mode: 0 Normal, 1 Standby, 2 Sleep, 3 Off, 4 Overtemp |
| irq_any_i | input | 1 | Some interrupt is pending |
| ci_pend_i | input | 1 | The cyclic interrupt is pending |
| rst_req_o | output | 1 | One-cycle system-reset request |
| ci_set_o | output | 1 | One-cycle strobe that sets the cyclic interrupt |
| wd_mode_o | output | 2 | Active mode: 00 off, 01 window, 10 timeout |

## Verification
Two events can land on the same tick: a software trigger and the timer overflow. The test provokes this by setting the period to 8 ticks, entering window mode, and placing the trigger on exactly the eighth tick. The expected result is a reset request, because the overflow takes priority.

Timeout mode has a second overlap: an overflow while the cyclic interrupt is already pending. This must produce a reset and no interrupt strobe. The test observes both outputs together over each run and checks that only the reset request appears.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic [2:0] {
    SYS_NORMAL   = 3'd0,
    SYS_STANDBY  = 3'd1,
    SYS_SLEEP    = 3'd2,
    SYS_OFF      = 3'd3,
    SYS_OVERTEMP = 3'd4
  } sys_mode_e;

  typedef enum logic [1:0] {
    WD_OFF     = 2'd0,
    WD_WINDOW  = 2'd1,
    WD_TIMEOUT = 2'd2
  } wd_mode_e;

  localparam logic [2:0] PERIOD_CODE_RST = 3'b100;
  localparam int         CODE_W          = 3;

endpackage

// File: rtl/wdog_mode_dec.sv
module wdog_mode_dec
  import wdog_pkg::*;
(
  input  logic       dis_i,
  input  logic [2:0] sys_i,
  input  logic       mc_i,
  input  logic       irq_i,
  output wd_mode_e   mode_o
);

  always_comb begin
    mode_o = WD_OFF;
    if (!dis_i) begin
      case (sys_mode_e'(sys_i))
        SYS_NORMAL:  mode_o = mc_i ? WD_TIMEOUT : WD_WINDOW;
        // bit at 1 parks the watchdog only while nothing is pending
        SYS_STANDBY: mode_o = (mc_i && !irq_i) ? WD_OFF : WD_TIMEOUT;
        default:     mode_o = WD_OFF;
      endcase
    end
  end

endmodule

// File: rtl/wdog_period_map.sv
module wdog_period_map #(
  parameter int TICKS_PER_MS = 1,
  parameter int CNT_W        = 13
) (
  input  logic [2:0]       code_i,
  output logic [CNT_W-1:0] period_o
);

  function automatic int code_to_ms(input logic [2:0] c);
    int ms;
    case (c)
      3'd6:    ms = 1024;
      3'd7:    ms = 4096;
      default: ms = 8 << c;
    endcase
    return ms;
  endfunction

  always_comb period_o = CNT_W'(code_to_ms(code_i) * TICKS_PER_MS);

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             early_o,
  output logic             ovf_o
);

  logic [CNT_W-1:0] cnt_q;

  assign ovf_o   = run_i && tick_i && (cnt_q == period_i - 1'b1);
  assign early_o = cnt_q < (period_i >> 1);

  always_ff @(posedge clk) begin
    if (rst || restart_i || !run_i || ovf_o) cnt_q <= '0;
    else if (tick_i)                          cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor
  import wdog_pkg::*;
#(
  parameter int TICKS_PER_MS = 1,
  localparam int MAX_TICKS   = 4096 * TICKS_PER_MS,
  localparam int CNT_W       = $clog2(MAX_TICKS + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_i,
  input  logic       trig_i,
  input  logic [2:0] trig_code_i,
  input  logic       trig_mc_i,
  input  logic       wd_dis_i,
  input  logic [2:0] sys_mode_i,
  input  logic       irq_any_i,
  input  logic       ci_pend_i,
  output logic       rst_req_o,
  output logic       ci_set_o,
  output logic [1:0] wd_mode_o
);

  logic [CODE_W-1:0] code_q;
  logic              mc_q;
  logic              dis_q;
  wd_mode_e          mode_q;
  wd_mode_e          mode;
  logic [CNT_W-1:0]  period;
  logic              early, ovf, run, mode_chg;
  logic              sys_active, dis_evt, mc_evt, mc_locked;
  logic              win_bad, to_ovf, rst_now, ci_now;

  wdog_mode_dec u_dec (
    .dis_i  (wd_dis_i),
    .sys_i  (sys_mode_i),
    .mc_i   (mc_q),
    .irq_i  (irq_any_i),
    .mode_o (mode)
  );

  wdog_period_map #(.TICKS_PER_MS(TICKS_PER_MS), .CNT_W(CNT_W)) u_map (
    .code_i   (code_q),
    .period_o (period)
  );

  assign mode_chg = (mode != mode_q);
  assign run      = (mode != WD_OFF) && !mode_chg;

  wdog_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (tick_i),
    .run_i     (run),
    .restart_i (rst_now || trig_i),
    .period_i  (period),
    .early_o   (early),
    .ovf_o     (ovf)
  );

  always_comb begin
    sys_active = (sys_mode_i == SYS_NORMAL) || (sys_mode_i == SYS_STANDBY);
    dis_evt    = (wd_dis_i != dis_q) && sys_active;
    mc_evt     = trig_i && (sys_mode_i == SYS_NORMAL) && (trig_mc_i != mc_q);
    mc_locked  = (sys_mode_i == SYS_STANDBY) && irq_any_i;
    // overflow wins over a trigger in the same tick
    win_bad    = (mode == WD_WINDOW) && (ovf || (trig_i && early));
    to_ovf     = (mode == WD_TIMEOUT) && ovf;
    rst_now    = dis_evt || mc_evt || win_bad || (to_ovf && ci_pend_i);
    ci_now     = to_ovf && !ci_pend_i && !rst_now;
  end

  always_ff @(posedge clk) begin
    dis_q <= wd_dis_i;
    if (rst) begin
      code_q    <= PERIOD_CODE_RST;
      mc_q      <= 1'b0;
      mode_q    <= WD_OFF;
      rst_req_o <= 1'b0;
      ci_set_o  <= 1'b0;
    end else begin
      mode_q    <= mode;
      rst_req_o <= rst_now;
      ci_set_o  <= ci_now;
      if (rst_now)     code_q <= PERIOD_CODE_RST;
      else if (trig_i) code_q <= trig_code_i;
      if (trig_i && !mc_locked) mc_q <= trig_mc_i;
    end
  end

  assign wd_mode_o = mode_q;

endmodule

// File: rtl/wdog_supervisor_chk.sv
module wdog_supervisor_chk (
  input logic       clk,
  input logic       rst,
  input logic       wd_dis_i,
  input logic [2:0] sys_mode_i,
  input logic       ci_pend_i,
  input logic       rst_req_o,
  input logic       ci_set_o,
  input logic [1:0] wd_mode_o
);

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!rst_req_o && !ci_set_o && wd_mode_o == 2'd0)); // R1

  AST_WINDOW_NEEDS_NORMAL: assert property (@(posedge clk) disable iff (rst)
    (wd_mode_o == 2'd1) |-> ($past(sys_mode_i) == 3'd0 && !$past(wd_dis_i))); // R2

  AST_CI_ONLY_TIMEOUT: assert property (@(posedge clk) disable iff (rst)
    ci_set_o |-> (wd_mode_o == 2'd2)); // R7

  AST_CI_NOT_PENDING: assert property (@(posedge clk) disable iff (rst)
    ci_set_o |-> !$past(ci_pend_i)); // R7

  AST_DIS_TOGGLE_RESET: assert property (@(posedge clk) disable iff (rst)
    ((wd_dis_i != $past(wd_dis_i)) && (sys_mode_i <= 3'd1)) |=> rst_req_o); // R9

  AST_RESET_OVER_CI: assert property (@(posedge clk) disable iff (rst)
    !(rst_req_o && ci_set_o)); // R12

endmodule

bind wdog_supervisor wdog_supervisor_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .wd_dis_i   (wd_dis_i),
  .sys_mode_i (sys_mode_i),
  .ci_pend_i  (ci_pend_i),
  .rst_req_o  (rst_req_o),
  .ci_set_o   (ci_set_o),
  .wd_mode_o  (wd_mode_o)
);

// File: tb/sim_wdog_supervisor.sv
`timescale 1ns/1ps
module sim_wdog_supervisor;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b1;
  logic       trig = 1'b0;
  logic [2:0] code = 3'd0;
  logic       trig_mc = 1'b0;
  logic       dis = 1'b0;
  logic [2:0] sys = 3'd2;
  logic       irq = 1'b0;
  logic       cip = 1'b0;
  logic       rst_req_o, ci_set_o;
  logic [1:0] wd_mode_o;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;
  bit  seen_rst, seen_ci;

  always #2.5 clk = ~clk;

  wdog_supervisor u0 (
    .clk(clk), .rst(rst), .tick_i(tick), .trig_i(trig), .trig_code_i(code),
    .trig_mc_i(trig_mc), .wd_dis_i(dis), .sys_mode_i(sys), .irq_any_i(irq),
    .ci_pend_i(cip), .rst_req_o(rst_req_o), .ci_set_o(ci_set_o), .wd_mode_o(wd_mode_o)
  );

  typedef struct packed {
    logic [3:0] req;
    logic [2:0] sys;
    logic       mc, dis, irq, ci;
    logic [7:0] k;
    logic       trg, e_rst, e_ci;
    logic [1:0] e_mode;
  } vec_t;

  // period code 000 = 8 ticks; k = ticks before the (optional) trigger edge
  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{4'd5, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd4,  1'b1, 1'b1, 1'b0, 2'd1}, // R5 early
    '{4'd5, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd5,  1'b1, 1'b0, 1'b0, 2'd1}, // R5 open half
    '{4'd6, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd8,  1'b1, 1'b1, 1'b0, 2'd1}, // R6 tie
    '{4'd6, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd8,  1'b0, 1'b1, 1'b0, 2'd1}, // R6 overflow
    '{4'd6, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd7,  1'b0, 1'b0, 1'b0, 2'd1}, // R6 one short
    '{4'd7, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd8,  1'b0, 1'b0, 1'b1, 2'd2}, // R7 ci set
    '{4'd7, 3'd1, 1'b0, 1'b0, 1'b0, 1'b1, 8'd8,  1'b0, 1'b1, 1'b0, 2'd2}, // R7 ci pending
    '{4'd3, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd8,  1'b0, 1'b0, 1'b1, 2'd2}, // R3 normal mc=1
    '{4'd4, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 8'd20, 1'b0, 1'b0, 1'b0, 2'd0}, // R4 sleep
    '{4'd4, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 8'd20, 1'b0, 1'b0, 1'b0, 2'd0}, // R4 off
    '{4'd4, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 8'd20, 1'b0, 1'b0, 1'b0, 2'd0}, // R4 overtemp
    '{4'd4, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 8'd20, 1'b0, 1'b0, 1'b0, 2'd0}, // R4 standby mc=1
    '{4'd4, 3'd1, 1'b1, 1'b0, 1'b1, 1'b0, 8'd8,  1'b0, 1'b0, 1'b1, 2'd2}, // R4 irq re-enables
    '{4'd4, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd20, 1'b0, 1'b0, 1'b0, 2'd0}  // R4 pin high
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic go(input int n, input bit dot, input bit tmc);
    for (int i = 0; i < n; i++) begin
      trig    = dot && (i == n - 1);
      trig_mc = tmc;
      code    = 3'd0;
      @(posedge clk);
      @(negedge clk);
      if (rst_req_o) seen_rst = 1'b1;
      if (ci_set_o)  seen_ci  = 1'b1;
    end
    trig = 1'b0;
  endtask

  // reset, then write code 000 and the given bit while the system sleeps
  task automatic prep(input logic d, input logic m);
    rst = 1'b1; sys = 3'd2; dis = d; irq = 1'b0; cip = 1'b0; trig = 1'b0; tick = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0; trig = 1'b1; trig_mc = m; code = 3'd0;
    @(negedge clk);
    trig = 1'b0;
    seen_rst = 1'b0; seen_ci = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    repeat (2) @(negedge clk);
    chk("R1 reset rst_req", rst_req_o, 0);
    chk("R1 reset ci_set", ci_set_o, 0);
    chk("R1 reset mode", wd_mode_o, 0);

    for (int i = 0; i < NV; i++) begin
      prep(VEC[i].dis, VEC[i].mc);
      sys = VEC[i].sys; irq = VEC[i].irq; cip = VEC[i].ci;
      go(VEC[i].k + 1, VEC[i].trg, VEC[i].mc);
      chk($sformatf("R%0d vec %0d rst", VEC[i].req, i), seen_rst, VEC[i].e_rst);
      chk($sformatf("R%0d vec %0d ci", VEC[i].req, i), seen_ci, VEC[i].e_ci);
      chk($sformatf("R%0d vec %0d mode", VEC[i].req, i), wd_mode_o, VEC[i].e_mode);
    end

    // R8 default period 128 after reset, window entered straight from reset
    rst = 1'b1; sys = 3'd0; dis = 1'b0; irq = 1'b0; cip = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0; seen_rst = 1'b0;
    go(128, 1'b0, 1'b0);
    chk("R8 default period no early reset", seen_rst, 0);
    go(1, 1'b0, 1'b0);
    chk("R8 default period overflow", seen_rst, 1);

    // R8 reset restores code 100 even though the write carried 000
    prep(1'b0, 1'b0); sys = 3'd0;
    go(3, 1'b1, 1'b0);
    chk("R5 early trigger", seen_rst, 1);
    seen_rst = 1'b0;
    go(127, 1'b0, 1'b0);
    chk("R8 restored period not yet", seen_rst, 0);
    go(1, 1'b0, 1'b0);
    chk("R8 restored period overflow", seen_rst, 1);

    // R8 no tick, no progress
    prep(1'b0, 1'b0); sys = 3'd0; tick = 1'b0;
    go(30, 1'b0, 1'b0);
    chk("R8 tick gating", seen_rst, 0);
    tick = 1'b1;

    // R9 disable pin toggles
    prep(1'b0, 1'b0); sys = 3'd0;
    go(3, 1'b0, 1'b0);
    dis = 1'b1;
    go(1, 1'b0, 1'b0);
    chk("R9 pin change normal", seen_rst, 1);
    prep(1'b0, 1'b0); sys = 3'd1;
    go(2, 1'b0, 1'b0);
    dis = 1'b1;
    go(1, 1'b0, 1'b0);
    chk("R9 pin change standby", seen_rst, 1);
    prep(1'b0, 1'b0);
    dis = 1'b1;
    go(2, 1'b0, 1'b0);
    chk("R9 pin change sleep", seen_rst, 0);

    // R10 bit change in Normal; control write in the open half
    prep(1'b0, 1'b0); sys = 3'd0;
    go(7, 1'b1, 1'b0);
    chk("R5 open half trigger", seen_rst, 0);
    prep(1'b0, 1'b0); sys = 3'd0;
    go(7, 1'b1, 1'b1);
    chk("R10 bit change normal", seen_rst, 1);
    go(2, 1'b0, 1'b0);
    chk("R10 new bit takes effect", wd_mode_o, 2);

    // R11 bit locked in Standby while an interrupt is pending
    prep(1'b0, 1'b0); sys = 3'd1; irq = 1'b1;
    go(2, 1'b0, 1'b0);
    go(1, 1'b1, 1'b1);
    chk("R11 locked write no reset", seen_rst, 0);
    irq = 1'b0;
    go(2, 1'b0, 1'b0);
    chk("R11 bit unchanged", wd_mode_o, 2);
    prep(1'b0, 1'b0); sys = 3'd1;
    go(2, 1'b0, 1'b0);
    go(1, 1'b1, 1'b1);
    go(2, 1'b0, 1'b0);
    chk("R4 bit accepted with nothing pending", wd_mode_o, 0);

    // R7 trigger restarts timeout count
    prep(1'b0, 1'b0); sys = 3'd1;
    go(7, 1'b1, 1'b0);
    go(7, 1'b0, 1'b0);
    chk("R7 restart delays overflow", seen_ci, 0);
    go(1, 1'b0, 1'b0);
    chk("R7 overflow after restart", seen_ci, 1);
    chk("R12 no reset with ci", seen_rst, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule